// File: doc/BRIEF.md
# Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable 11-bit modulus. It is built as a frequency synthesizer loop would build it, not with one wide counter. A small prescaler runs at the full input rate and divides by either 8 or 9. A slow M counter counts prescaler cycles. A 3-bit swallow counter (A) picks how many of those prescaler cycles use the longer divide-by-9 setting. One output frame therefore lasts M×8+A input cycles. At the end of each frame the block emits a single pulse one input clock wide.

The divide word is read only at a frame boundary, so a new setting never shortens or stretches the frame in progress. A word whose swallow count exceeds its M count cannot be realised as such. The block flags that word on an error output and runs it with the swallow count clamped to M. A word with M equal to zero is also flagged, and it runs as a plain divide-by-8. Reset clears every counter. The first frame then begins on the first clock edge after reset is released.

Top module: `pulse_swallow_div`

## Requirements
- R1: The divide word splits into swallow count A = divWord[2:0] and M = divWord[10:3]. For 1 ≤ M and A ≤ M, divPulse repeats every 8·M+A input clock cycles. The prescaler divides by 9 for the first A prescaler cycles of a frame and by 8 for the remaining M−A cycles.
- R2: divPulse is high for exactly one input clock cycle per frame.
- R3: Edge 0 is the first rising edge of clk with rstN high. The first divPulse is high just after edge N, where N is the modulus of the word present at edge 0.
- R4: While rstN is low, divPulse and cfgError are 0.
- R5: divWord is sampled only on the edge that ends a frame, and on edge 0. A change made in mid-frame changes neither the length of the current frame nor cfgError until that frame ends.
- R6: If A > M (with M ≥ 1), cfgError is 1 for every frame run with that word, and the frame lasts 9·M cycles. cfgError returns to 0 at the first boundary that samples a legal word.
- R7: If M = 0, cfgError is 1 and the frame lasts 8 cycles, whatever the value of A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rstN | input | 1 | Asynchronous active-low reset |
| divWord | input | 11 | Divide word: M in bits 10:3, swallow count in bits 2:0 |
| divPulse | output | 1 | One-cycle pulse at the end of each frame |
| cfgError | output | 1 | The word in effect for the current frame is illegal |

## Verification
Some behaviour is checked by assertions on every cycle:
- the swallow count left never exceeds the M count left;
- once swallowing stops inside a frame, it does not resume;
- the pulse never lasts two cycles, and no pulse appears before the first frame has started;
- the error flag changes only at a frame boundary.

Other behaviour only the bench scenarios can show, because it appears at the ports only as pulse spacing. This covers the exact frame lengths at the smallest, largest and A = M boundaries, the timing of the first pulse after reset, the deferral of a word changed in mid-frame, and the clamped lengths chosen for illegal words.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  // Strobes handed from the frame control to the counting datapath
  typedef struct packed {
    logic tick;   // prescaler finishes a cycle on this edge
    logic load;   // frame ends on this edge: reload from the divide word
  } swdivStrobe_t;
endpackage

// File: rtl/swdiv_datapath.sv
module swdiv_datapath
  import swdiv_pkg::*;
#(
  parameter int MWidth = 8,
  parameter int AWidth = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  swdivStrobe_t      ctl,
  input  logic [MWidth-1:0] effM,
  input  logic [AWidth-1:0] effA,
  output logic              preZero,
  output logic              mLast
);
  localparam int Base  = 2 ** AWidth;
  localparam int PreW  = AWidth + 1;
  localparam logic [PreW-1:0] PreLong  = PreW'(Base);
  localparam logic [PreW-1:0] PreShort = PreW'(Base - 1);

  logic [PreW-1:0]   preCnt;
  logic [MWidth-1:0] mLeft;
  logic [AWidth-1:0] aLeft;
  logic [AWidth-1:0] aNext;

  // swallow cycles left once the current prescaler cycle retires
  assign aNext = (aLeft != '0) ? aLeft - AWidth'(1) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      mLeft  <= '0;
      aLeft  <= '0;
    end else if (ctl.load) begin
      mLeft  <= effM;
      aLeft  <= effA;
      preCnt <= (effA != '0) ? PreLong : PreShort;
    end else if (ctl.tick) begin
      mLeft  <= mLeft - MWidth'(1);
      aLeft  <= aNext;
      preCnt <= (aNext != '0) ? PreLong : PreShort;
    end else begin
      preCnt <= preCnt - PreW'(1);
    end
  end

  assign preZero = (preCnt == '0);
  assign mLast   = (mLeft <= MWidth'(1));

  // R6
  swallow_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    MWidth'(aLeft) <= mLeft);

  // R1
  swallow_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.tick && !ctl.load && aLeft == '0) |=> (aLeft == '0));

  // R1
  prescale_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aLeft == '0 && !ctl.load) |-> (preCnt <= PreShort));
endmodule

// File: rtl/swdiv_control.sv
module swdiv_control
  import swdiv_pkg::*;
#(
  parameter int MWidth = 8,
  parameter int AWidth = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [MWidth+AWidth-1:0] divWord,
  input  logic                     preZero,
  input  logic                     mLast,
  output swdivStrobe_t             ctl,
  output logic [MWidth-1:0]        effM,
  output logic [AWidth-1:0]        effA,
  output logic                     divPulse,
  output logic                     cfgError
);
  logic [MWidth-1:0] mRaw;
  logic [AWidth-1:0] aRaw;
  logic              zeroM;
  logic              overA;
  logic              started;

  assign aRaw  = divWord[AWidth-1:0];
  assign mRaw  = divWord[MWidth+AWidth-1:AWidth];
  assign zeroM = (mRaw == '0);
  assign overA = (MWidth'(aRaw) > mRaw);

  // word decode with clamping of illegal settings
  always_comb begin
    if (zeroM) begin
      effM = MWidth'(1);
      effA = '0;
    end else if (overA) begin
      effM = mRaw;
      effA = mRaw[AWidth-1:0];
    end else begin
      effM = mRaw;
      effA = aRaw;
    end
  end

  assign ctl.tick = preZero;
  assign ctl.load = preZero && mLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started  <= 1'b0;
      divPulse <= 1'b0;
      cfgError <= 1'b0;
    end else begin
      divPulse <= ctl.load && started;
      if (ctl.load) begin
        started  <= 1'b1;
        cfgError <= zeroM || overA;
      end
    end
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse);

  // R3
  first_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    !started |-> !divPulse);

  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(cfgError));
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import swdiv_pkg::*;
#(
  parameter int MWidth = 8,
  parameter int AWidth = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [MWidth+AWidth-1:0] divWord,
  output logic                     divPulse,
  output logic                     cfgError
);
  swdivStrobe_t      ctl;
  logic [MWidth-1:0] effM;
  logic [AWidth-1:0] effA;
  logic              preZero;
  logic              mLast;

  swdiv_control #(.MWidth(MWidth), .AWidth(AWidth)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .divWord  (divWord),
    .preZero  (preZero),
    .mLast    (mLast),
    .ctl      (ctl),
    .effM     (effM),
    .effA     (effA),
    .divPulse (divPulse),
    .cfgError (cfgError)
  );

  swdiv_datapath #(.MWidth(MWidth), .AWidth(AWidth)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .effM    (effM),
    .effA    (effA),
    .preZero (preZero),
    .mLast   (mLast)
  );
endmodule

// File: tb/pulse_swallow_div_test.sv
`timescale 1ns/1ps
module pulse_swallow_div_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] divWord = '0;
  logic        divPulse;
  logic        cfgError;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  pulse_swallow_div uut (
    .clk(clk), .rstN(rstN), .divWord(divWord),
    .divPulse(divPulse), .cfgError(cfgError)
  );

  always #2.5 clk = ~clk;

  // expected frame length from R1, R6, R7
  function automatic int modOf(input logic [10:0] w);
    int m = int'(w[10:3]);
    int a = int'(w[2:0]);
    if (m == 0) return 8;
    if (a > m) return 9 * m;
    return 8 * m + a;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // R4: hold reset, check outputs, release at a falling edge
  task automatic applyReset(input logic [10:0] w);
    rstN = 1'b0;
    divWord = w;
    repeat (3) @(negedge clk);
    check(divPulse == 1'b0, "R4 divPulse in reset", int'(divPulse), 0);
    check(cfgError == 1'b0, "R4 cfgError in reset", int'(cfgError), 0);
    rstN = 1'b1;
  endtask

  // R3: index of the edge after which the first pulse is seen (edge 0 first)
  task automatic firstPulse(input int expN, input string tag);
    int at = -1;
    for (int i = 0; i < 5000 && at < 0; i++) begin
      @(posedge clk); @(negedge clk);
      if (divPulse) at = i;
    end
    check(at == expN, tag, at, expN);
  endtask

  // R1/R2/R5: cycles until next pulse, optionally changing the word in mid-frame
  task automatic period(input int expN, input int changeAt,
                        input logic [10:0] newWord, input string tag);
    int k = 0;
    bit seen = 0;
    while (!seen && k < 5000) begin
      @(posedge clk); @(negedge clk);
      k++;
      if (k == 1) check(divPulse == 1'b0, "R2 pulse one cycle wide", int'(divPulse), 0);
      if (divPulse) seen = 1;
      else if (k == changeAt) divWord = newWord;
    end
    check(seen && k == expN, tag, k, expN);
  endtask

  task automatic runLegal(input logic [10:0] w);
    int n = modOf(w);
    applyReset(w);
    firstPulse(n, $sformatf("R3 first pulse word %0d", w));
    check(cfgError == 1'b0, "R1 legal word no error", int'(cfgError), 0);
    period(n, 0, w, $sformatf("R1 period word %0d", w));
    period(n, 0, w, $sformatf("R1 second period word %0d", w));
  endtask

  task automatic midChange;
    applyReset(11'd40);
    firstPulse(40, "R3 first pulse before change");
    period(40, 10, 11'd72, "R5 current frame keeps old length");
    period(72, 0, 11'd72, "R5 new word in next frame");
  endtask

  task automatic illegalOver;
    applyReset(11'h020);
    firstPulse(32, "R3 first pulse legal 32");
    period(32, 5, 11'h015, "R5 illegal word deferred");
    check(cfgError == 1'b1, "R6 error raised at boundary", int'(cfgError), 1);
    period(18, 0, 11'h015, "R6 A>M runs 9*M");
    check(cfgError == 1'b1, "R6 error persists", int'(cfgError), 1);
    period(18, 3, 11'h020, "R6 last clamped frame");
    check(cfgError == 1'b0, "R6 error clears on legal word", int'(cfgError), 0);
    period(32, 0, 11'h020, "R6 legal length restored");
  endtask

  task automatic midErrorHold;
    applyReset(11'h020);
    firstPulse(32, "R3 first pulse 32");
    repeat (4) @(negedge clk);
    divWord = 11'h015;
    repeat (2) @(negedge clk);
    check(cfgError == 1'b0, "R5 error unchanged mid-frame", int'(cfgError), 0);
  endtask

  task automatic zeroM;
    applyReset(11'h005);
    firstPulse(8, "R7 M=0 first frame 8");
    check(cfgError == 1'b1, "R7 M=0 flagged", int'(cfgError), 1);
    period(8, 0, 11'h005, "R7 M=0 period 8");
  endtask

  initial begin
    runLegal(11'h008);   // M=1 A=0 -> 8, smallest
    runLegal(11'h009);   // M=1 A=1 -> 9
    runLegal(11'd27);    // M=3 A=3 -> 27, A equals M
    runLegal(11'd56);    // M=7 A=0
    runLegal(11'd57);    // M=7 A=1
    runLegal(11'd100);   // M=12 A=4
    runLegal(11'd2047);  // M=255 A=7, largest
    midChange();
    illegalOver();
    midErrorHold();
    zeroM();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule